// File: doc/BRIEF.md
# DMA Buffer Descriptor Ring Walker

This block runs one DMA channel through a circular table of buffer descriptors held in memory. Each descriptor is two 32-bit words. The first word holds a status/control halfword in bits 31:16 and the byte length in bits 15:0. The second word is the buffer address. The status/control halfword has six handling bits and ten device bits. The walker reads the handling bits. It never interprets the device bits: it passes them to the data mover and writes them back unchanged.

When the channel is enabled, the walker latches the table base and the direction (transmit or receive) and starts at index 0. For each descriptor it does the following:
- It reads both words over a word-wide memory port.
- It offers the buffer to a data mover on a valid/ready stream. The offer holds steady while `buf_ready` is low, so the mover may apply back-pressure for as long as it needs.
- It waits for the mover's completion handshake.
- It writes the first word back with Ready cleared. In receive mode that write also carries the number of bytes actually stored.

The walker returns to the table base after a descriptor carrying the wrap flag, or after the last index of its 256-entry space. A descriptor that is not ready when it is fetched stops the channel with an error. An out-of-range length also stops the channel with an error. The walker does not stall and wait in either case. A packet may span consecutive descriptors; the last-in-packet flag is forwarded to the mover.

Top module: `dma_ring_walker`

## Requirements
- R1: Descriptor n is read at table_base + 8·n: first the control word, then the pointer word at +4. Every memory address is word aligned.
- R2: If bit 31 of the control word (Ready) is 0 when that word is read, the walker raises `err` and sets `err_idx` to the index. It then makes no further memory access and no further offer.
- R3: The offer carries the following fields. `buf_ptr` is the pointer word. `buf_len` is control bits 15:0. `buf_dev` is control bits 25:16. `buf_last` is control bit 28. While `buf_valid` is high and `buf_ready` is low, `buf_valid` and all these fields hold their values.
- R4: In transmit mode, a control word whose length is above 4080 causes the error response of R2 for that index, with no offer.
- R5: In receive mode, the descriptor length field is not checked. The walker writes back the `cmp_len` value that the mover reports. A `cmp_len` above 4080 causes the error response instead of a write-back.
- R6: After the completion handshake, the control word is written back with bit 31 cleared and bits 30:16 unchanged. The low half carries the original length in transmit mode and `cmp_len` in receive mode.
- R7: After a descriptor whose bit 30 (Wrap) is set, the next index is 0.
- R8: With no Wrap bit present, the walker goes from index 255 back to index 0.
- R9: A rising edge of `enable` clears `err`, restarts at index 0 and makes `busy` high. `err` stays set while the channel is disabled.
- R10: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values until `mem_ack`.
- R11: After reset, `busy`, `err`, `mem_req`, `buf_valid` and `cmp_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; a rising edge starts the walker at index 0 |
| rx_mode | input | 1 | 1 = receive, 0 = transmit; latched when the channel is enabled |
| table_base | input | AW | Table base address (8-byte aligned); latched when the channel is enabled |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; carries read data for reads |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| buf_valid | output | 1 | Buffer offer valid |
| buf_ready | input | 1 | Mover accepts the offer |
| buf_ptr | output | 32 | Buffer address |
| buf_len | output | 16 | Descriptor length field |
| buf_dev | output | 10 | Device bits, passed through unchanged |
| buf_last | output | 1 | Last buffer of the packet |
| cmp_valid | input | 1 | Mover reports that the buffer is finished |
| cmp_ready | output | 1 | Walker accepts the completion |
| cmp_len | input | 16 | Bytes stored (receive mode) |
| busy | output | 1 | Walking the ring |
| err | output | 1 | Channel stopped on an error |
| err_idx | output | IDX_W | Index of the failing descriptor |

## Verification
A wrong index or base shows up at the very next descriptor fetch as a wrong `mem_addr`. The bench sees it as a swapped buffer pointer at the next offer, within about a dozen cycles. A wrap that fires early or late shows up on the following lap: the walker reaches a descriptor whose Ready bit it has already cleared, so `err_idx` reports the wrong index or too many or too few offers appear. A bad write-back path corrupts the control word in memory; the bench reads that word back once the run stops.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  // control word bit positions (upper halfword = handling + device bits)
  localparam int RDY_B  = 31;
  localparam int WRP_B  = 30;
  localparam int CONT_B = 29;
  localparam int LAST_B = 28;
  localparam int DEV_LO = 16;
  localparam int DEV_W  = 10;
  localparam int LEN_W  = 16;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD1, S_HAND, S_WAIT, S_WB, S_ERR
  } walk_state_t;
endpackage

// File: rtl/dmaw_ring_idx.sv
module dmaw_ring_idx #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             wrap_now,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx <= '0;
    else if (clear)
      idx <= '0;
    else if (step) begin
      if (wrap_now || idx == LAST_IDX)
        idx <= '0;
      else
        idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/dmaw_addr_gen.sv
module dmaw_addr_gen #(
  parameter int AW    = 32,
  parameter int IDX_W = 8
) (
  input  logic [AW-1:0]    base,
  input  logic [IDX_W-1:0] idx,
  input  logic             hi_word,
  output logic [AW-1:0]    addr
);
  localparam int OFS_W = IDX_W + 3;

  logic [OFS_W-1:0] ofs;
  assign ofs  = {idx, hi_word, 2'b00};
  assign addr = base + AW'(ofs);
endmodule

// File: rtl/dmaw_desc_chk.sv
module dmaw_desc_chk #(
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 4080
) (
  input  logic             ready_bit,
  input  logic [LEN_W-1:0] desc_len,
  input  logic [LEN_W-1:0] done_len,
  output logic             not_ready,
  output logic             tx_len_bad,
  output logic             rx_len_bad
);
  localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_LEN);

  assign not_ready  = !ready_bit;
  assign tx_len_bad = desc_len > LIMIT;
  assign rx_len_bad = done_len > LIMIT;
endmodule

// File: rtl/dma_ring_walker.sv
module dma_ring_walker
  import dmaw_pkg::*;
#(
  parameter int AW      = 32,
  parameter int IDX_W   = 8,
  parameter int MAX_LEN = 4080
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 rx_mode,
  input  logic [AW-1:0]        table_base,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic                 mem_ack,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 buf_valid,
  input  logic                 buf_ready,
  output logic [WORD_W-1:0]    buf_ptr,
  output logic [LEN_W-1:0]     buf_len,
  output logic [DEV_W-1:0]     buf_dev,
  output logic                 buf_last,
  input  logic                 cmp_valid,
  output logic                 cmp_ready,
  input  logic [LEN_W-1:0]     cmp_len,
  output logic                 busy,
  output logic                 err,
  output logic [IDX_W-1:0]     err_idx
);
  walk_state_t          state;
  logic                 en_q;
  logic                 mode_q;
  logic [AW-1:0]        base_q;
  logic [WORD_W-1:0]    ctl_q;
  logic [WORD_W-1:0]    ptr_q;
  logic [LEN_W-1:0]     wb_len_q;
  logic [IDX_W-1:0]     idx;
  logic                 start;
  logic                 idx_step;
  logic                 not_ready, tx_len_bad, rx_len_bad;

  assign start    = enable && !en_q;
  assign idx_step = enable && !start && (state == S_WB) && mem_ack;

  dmaw_ring_idx #(.IDX_W(IDX_W)) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .step     (idx_step),
    .wrap_now (ctl_q[WRP_B]),
    .idx      (idx)
  );

  dmaw_addr_gen #(.AW(AW), .IDX_W(IDX_W)) u_addr (
    .base    (base_q),
    .idx     (idx),
    .hi_word (state == S_RD1),
    .addr    (mem_addr)
  );

  dmaw_desc_chk #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_chk (
    .ready_bit  (mem_rdata[RDY_B]),
    .desc_len   (mem_rdata[LEN_W-1:0]),
    .done_len   (cmp_len),
    .not_ready  (not_ready),
    .tx_len_bad (tx_len_bad),
    .rx_len_bad (rx_len_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      en_q     <= 1'b0;
      mode_q   <= 1'b0;
      base_q   <= '0;
      ctl_q    <= '0;
      ptr_q    <= '0;
      wb_len_q <= '0;
      err      <= 1'b0;
      err_idx  <= '0;
    end else begin
      en_q <= enable;
      if (start) begin
        state  <= S_RD0;
        err    <= 1'b0;
        mode_q <= rx_mode;
        base_q <= table_base;
      end else if (!enable) begin
        state <= S_IDLE;
      end else begin
        unique case (state)
          S_RD0: if (mem_ack) begin
            ctl_q <= mem_rdata;
            if (not_ready || (!mode_q && tx_len_bad)) begin
              state   <= S_ERR;
              err     <= 1'b1;
              err_idx <= idx;
            end else begin
              state <= S_RD1;
            end
          end
          S_RD1: if (mem_ack) begin
            ptr_q <= mem_rdata;
            state <= S_HAND;
          end
          S_HAND: if (buf_ready) state <= S_WAIT;
          S_WAIT: if (cmp_valid) begin
            if (mode_q && rx_len_bad) begin
              state   <= S_ERR;
              err     <= 1'b1;
              err_idx <= idx;
            end else begin
              wb_len_q <= mode_q ? cmp_len : ctl_q[LEN_W-1:0];
              state    <= S_WB;
            end
          end
          S_WB:   if (mem_ack) state <= S_RD0;
          S_ERR:  state <= S_ERR;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign mem_req   = (state == S_RD0) || (state == S_RD1) || (state == S_WB);
  assign mem_we    = (state == S_WB);
  assign mem_wdata = {1'b0, ctl_q[WORD_W-2:LEN_W], wb_len_q};

  assign buf_valid = (state == S_HAND);
  assign buf_ptr   = ptr_q;
  assign buf_len   = ctl_q[LEN_W-1:0];
  assign buf_dev   = ctl_q[DEV_LO +: DEV_W];
  assign buf_last  = ctl_q[LAST_B];
  assign cmp_ready = (state == S_WAIT);
  assign busy      = (state != S_IDLE) && (state != S_ERR);
endmodule

// File: rtl/dmaw_walker_chk.sv
module dmaw_walker_chk #(
  parameter int AW      = 32,
  parameter int IDX_W   = 8,
  parameter int MAX_LEN = 4080
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          rx_mode,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          buf_valid,
  input logic          buf_ready,
  input logic [31:0]   buf_ptr,
  input logic [15:0]   buf_len,
  input logic [9:0]    buf_dev,
  input logic          buf_last,
  input logic          err
);
  // R1
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && enable |=>
      mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R3
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !buf_ready && enable |=>
      buf_valid && $stable(buf_ptr) && $stable(buf_len) &&
      $stable(buf_dev) && $stable(buf_last));

  // R6
  wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  // R4
  tx_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !rx_mode |-> buf_len <= 16'(MAX_LEN));

  // R2
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !buf_valid && !mem_req);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && enable && $past(enable) |=> err);
endmodule

bind dma_ring_walker dmaw_walker_chk #(
  .AW(AW), .IDX_W(IDX_W), .MAX_LEN(MAX_LEN)
) u_walker_chk (.*);

// File: tb/dma_ring_walker_test.sv
module dma_ring_walker_test;
  localparam logic [31:0] MB = 32'h0000_4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        enable = 1'b0, rx_mode = 1'b0;
  logic [31:0] table_base = MB;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        buf_valid, buf_ready, buf_last;
  logic [31:0] buf_ptr;
  logic [15:0] buf_len;
  logic [9:0]  buf_dev;
  logic        cmp_valid, cmp_ready;
  logic [15:0] cmp_len;
  logic        busy, err;
  logic [7:0]  err_idx;

  dma_ring_walker uut (.*);

  // memory model with preload port
  logic [31:0] mem [0:1023];
  logic        pl_en = 1'b0;
  logic [31:0] pl_addr = '0, pl_data = '0;
  logic        bad_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; bad_addr <= 1'b0;
    end else begin
      if (pl_en) mem[(pl_addr - MB) >> 2] <= pl_data;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_addr < MB || mem_addr >= MB + 32'd4096) bad_addr <= 1'b1;
        else begin
          mem_rdata <= mem[(mem_addr - MB) >> 2];
          if (mem_we) mem[(mem_addr - MB) >> 2] <= mem_wdata;
        end
      end else mem_ack <= 1'b0;
    end
  end

  // data mover model
  int          hcount, big_at = -1;
  logic [31:0] lg_ptr [0:1023];
  logic [15:0] lg_len [0:1023];
  logic [9:0]  lg_dev [0:1023];
  logic        lg_last[0:1023];
  logic        pend;
  logic [7:0]  stall;

  function automatic logic [15:0] rx_len(input int k);
    return (k % 5 == 1) ? 16'd4080 : 16'((k * 13 + 2) % 4000);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hcount <= 0; pend <= 1'b0; cmp_valid <= 1'b0; cmp_len <= '0;
      buf_ready <= 1'b0; stall <= '0;
    end else begin
      stall     <= stall + 1'b1;
      buf_ready <= (stall % 3) != 0;
      if (!enable) begin
        pend <= 1'b0; cmp_valid <= 1'b0;
      end else begin
        if (buf_valid && buf_ready) begin
          lg_ptr[hcount] <= buf_ptr; lg_len[hcount] <= buf_len;
          lg_dev[hcount] <= buf_dev; lg_last[hcount] <= buf_last;
          hcount <= hcount + 1; pend <= 1'b1;
        end
        if (pend && !cmp_valid) begin
          cmp_valid <= 1'b1;
          cmp_len   <= (hcount - 1 == big_at) ? 16'd4081 : rx_len(hcount - 1);
        end
        if (cmp_valid && cmp_ready) begin
          cmp_valid <= 1'b0; pend <= 1'b0;
        end
      end
    end
  end

  int checks = 0, errors = 0;
  logic [31:0] exp_w0 [0:255];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); pl_en = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk); pl_en = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] base, input int i,
                          input logic [31:0] w0, input logic [31:0] w1);
    put(base + 32'(8 * i), w0);
    put(base + 32'(8 * i + 4), w1);
    exp_w0[i] = w0;
  endtask

  function automatic logic [31:0] mk_w0(input bit rdy, input bit wrp, input bit lst,
                                        input int dev, input int len);
    return {rdy, wrp, 1'b0, lst, 2'b00, 10'(dev), 16'(len)};
  endfunction

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[(a - MB) >> 2];
  endfunction

  task automatic run_scn(input bit rx, input logic [31:0] base, output int h0);
    @(negedge clk); enable = 1'b0; rx_mode = rx; table_base = base;
    repeat (2) @(negedge clk);
    enable = 1'b1; h0 = hcount;
    @(negedge clk);
    chk("R9 busy after enable", 32'(busy), 32'd1);
    chk("R9 err cleared", 32'(err), 32'd0);
    for (int n = 0; n < 20000 && !err; n++) @(negedge clk);
    chk("R2 run stops with err", 32'(err), 32'd1);
  endtask

  task automatic main_seq();
    int h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 busy", 32'(busy), 0);
    chk("R11 err", 32'(err), 0);
    chk("R11 mem_req", 32'(mem_req), 0);
    chk("R11 buf_valid", 32'(buf_valid), 0);
    chk("R11 cmp_ready", 32'(cmp_ready), 0);

    // A: transmit, wrap at 4, length 4080 at index 1
    for (int i = 0; i < 6; i++)
      put_desc(MB, i, mk_w0(1, i == 4, i % 2, i * 37 + 5, i == 1 ? 4080 : 100 + i),
               32'h8000_0000 + 32'(i * 32'h1000));
    run_scn(0, MB, h0);
    chk("R7 offers before wrap", 32'(hcount - h0), 32'd5);
    chk("R7 second lap hits index 0", 32'(err_idx), 32'd0);
    for (int i = 0; i < 5; i++) begin
      chk("R1 R3 ptr", lg_ptr[h0 + i], 32'h8000_0000 + 32'(i * 32'h1000));
      chk("R3 R4 len", 32'(lg_len[h0 + i]), 32'(exp_w0[i][15:0]));
      chk("R3 dev", 32'(lg_dev[h0 + i]), 32'(exp_w0[i][25:16]));
      chk("R3 last", 32'(lg_last[h0 + i]), 32'(i % 2));
      chk("R6 tx writeback", rd(MB + 32'(8 * i)), exp_w0[i] & 32'h7FFF_FFFF);
    end
    chk("R7 entry 5 untouched", rd(MB + 32'd40), exp_w0[5]);
    @(negedge clk); enable = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 err held while disabled", 32'(err), 32'd1);
    chk("R9 busy low while disabled", 32'(busy), 32'd0);

    // B: receive, 256 entries, no wrap bit, oversize length fields
    for (int i = 0; i < 256; i++)
      put_desc(MB, i, mk_w0(1, 0, i % 3 == 0, i * 11, 5000 - i),
               32'h1000_0000 + 32'(i * 64));
    run_scn(1, MB, h0);
    chk("R8 offers over full ring", 32'(hcount - h0), 32'd256);
    chk("R8 forced wrap to 0", 32'(err_idx), 32'd0);
    for (int i = 0; i < 256; i++) begin
      chk("R1 R8 ptr", lg_ptr[h0 + i], 32'h1000_0000 + 32'(i * 64));
      chk("R5 R6 rx writeback", rd(MB + 32'(8 * i)),
          {1'b0, exp_w0[i][30:16], rx_len(h0 + i)});
    end

    // C: transmit, length 4081 at index 2, other base
    for (int i = 0; i < 8; i++)
      put_desc(MB + 32'h800, i, mk_w0(1, i == 7, 0, i, i == 2 ? 4081 : 64),
               32'h2000_0000 + 32'(i * 32'h100));
    run_scn(0, MB + 32'h800, h0);
    chk("R4 offers before bad length", 32'(hcount - h0), 32'd2);
    chk("R4 err_idx", 32'(err_idx), 32'd2);
    chk("R4 bad entry not written", rd(MB + 32'h800 + 32'd16), exp_w0[2]);
    chk("R1 ptr at other base", lg_ptr[h0 + 1], 32'h2000_0100);

    // D: receive, mover reports 4081 at fourth buffer
    for (int i = 0; i < 6; i++)
      put_desc(MB, i, mk_w0(1, i == 5, 1, 3, 200), 32'h3000_0000 + 32'(i));
    @(negedge clk); big_at = hcount + 3;
    run_scn(1, MB, h0);
    chk("R5 offers", 32'(hcount - h0), 32'd4);
    chk("R5 err_idx", 32'(err_idx), 32'd3);
    chk("R5 oversize not written", rd(MB + 32'd24), exp_w0[3]);
    chk("R5 prior written", rd(MB + 32'd16), {1'b0, exp_w0[2][30:16], rx_len(h0 + 2)});
    big_at = -1;

    // E: transmit, index 3 not ready
    for (int i = 0; i < 8; i++)
      put_desc(MB, i, mk_w0(i != 3, i == 7, 0, 0, 10), 32'h4000_0000 + 32'(i));
    run_scn(0, MB, h0);
    chk("R2 offers before not-ready", 32'(hcount - h0), 32'd3);
    chk("R2 err_idx", 32'(err_idx), 32'd3);
    chk("R2 no offer pending", 32'(buf_valid), 32'd0);
    chk("R1 addresses in table", 32'(bad_addr), 32'd0);
    @(negedge clk); enable = 1'b0;
  endtask

  initial begin
    bit wd = 1'b0;
    fork
      main_seq();
      begin repeat (150000) @(posedge clk); wd = 1'b1; end
    join_any
    disable fork;
    if (wd) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule